// File: doc/BRIEF.md
# Synthesizer Loop Divider and Phase Comparator

This block is the digital heart of a frequency synthesizer loop for a tuning receiver. A slow crystal time base is counted down to one of seven comparison frequencies. The local-oscillator pulse train is counted down by a programmable ratio. The two divided edge streams are compared, and the result drives a three-state error indication (pull up, pull down, or float) together with a sticky loss-of-lock flag. The analog pump, filter and oscillator sit outside the block.

The design runs on one fast system clock. The crystal and the oscillator are each presented as single-cycle strobes in that domain. In the high band, a 16/17 two-modulus prescaler feeds a program counter, so the ratio is N = 16·P + A. In the low band, the prescaler is bypassed and the ratio is P. A stop control covers halt, backup and loop-stop: it floats the error output and restarts both dividers.

Top module: `pll_synth_core`

## Requirements
- R1: After reset, `err_drive` is 0 and `unlock` is 0.
- R2: `ref_sel` picks how many crystal strobes make one reference edge: codes 0..6 select 75, 25, 24, 15, 12, 6 and 3, and code 7 selects 75. With a 75 kHz crystal these codes give 1, 3, 3.125, 5, 6.25, 12.5 and 25 kHz.
- R3: With `band_fm` = 1, one divided edge occurs every N = 16·P + A oscillator strobes. The 16/17 prescaler makes this count. P = 0 is taken as 1, and A greater than P is taken as P.
- R4: With `band_fm` = 0, one divided edge occurs every P oscillator strobes (P = 0 is taken as 1), and A has no effect.
- R5: A divided edge that arrives with no reference edge pending drives the error output high (`err_drive` = 1, `err_level` = 1) from the next cycle until the next reference edge.
- R6: A reference edge that arrives with no divided edge pending drives the error output low (`err_drive` = 1, `err_level` = 0) from the next cycle until the next divided edge.
- R7: When a divided edge and a reference edge meet, the error output floats (`err_drive` = 0). This holds whether the two edges fall in the same cycle or the second edge ends a pending pulse.
- R8: While `loop_stop` is 1, the error output floats from the next cycle and both dividers and the lock monitor restart. The `unlock` flag keeps its value.
- R9: `unlock` is set at a reference edge if the reference period ending there held a number of divided edges other than one. A divided edge in the same cycle as the reference edge counts toward that period. The first reference edge after reset or stop only opens the first period.
- R10: `unlock` stays set until a cycle with `unlock_ack` = 1 clears it. A new set in that same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_stb | input | 1 | One-cycle strobe per crystal period |
| lo_stb | input | 1 | One-cycle strobe per oscillator period |
| band_fm | input | 1 | 1: prescaled high band, 0: direct low band |
| ref_sel | input | 3 | Reference divisor code |
| prog_cnt | input | 12 | Program count P |
| swal_cnt | input | 4 | Swallow count A |
| loop_stop | input | 1 | Halt/backup/loop-stop: float output, restart dividers |
| unlock_ack | input | 1 | Read strobe clearing the unlock flag |
| err_drive | output | 1 | 1: error output driven, 0: high impedance |
| err_level | output | 1 | Driven level: 1 pump up, 0 pump down |
| unlock | output | 1 | Sticky loss-of-lock flag |

## Verification
On every cycle, the assertions check the local comparator rules. A lone edge on either side starts the matching drive, meeting edges float the output, and the output holds steady with no edges. Stop floats the output, and the flag only rises at a reference edge and only falls on a read. The exact divide ratios can only be shown by the bench's scenarios, which compare every cycle against a model that counts edges directly. These ratios are the reference table, 16·P + A with clamping, and the low-band bypass. The scenarios also cover the per-period edge count behind the unlock flag and the coincident-edge case.

// File: rtl/pll_synth_pkg.sv
package pll_synth_pkg;

  localparam int PROG_W = 12;
  localparam int SWAL_W = 4;
  localparam int REF_W  = 7;
  localparam int PRE_W  = 5;
  localparam int SEL_W  = 3;

  typedef enum logic {BAND_LOW = 1'b0, BAND_HIGH = 1'b1} band_e;

  // Crystal strobes per reference edge for each selection code.
  function automatic logic [REF_W-1:0] ref_divisor(input logic [SEL_W-1:0] sel);
    logic [REF_W-1:0] d;
    case (sel)
      3'd1:    d = REF_W'(25);
      3'd2:    d = REF_W'(24);
      3'd3:    d = REF_W'(15);
      3'd4:    d = REF_W'(12);
      3'd5:    d = REF_W'(6);
      3'd6:    d = REF_W'(3);
      default: d = REF_W'(75);
    endcase
    return d;
  endfunction

  // A program count of zero is treated as one.
  function automatic logic [PROG_W-1:0] prog_eff(input logic [PROG_W-1:0] p);
    return (p == '0) ? PROG_W'(1) : p;
  endfunction

  // Swallow count clamped to the program count.
  function automatic logic [SWAL_W-1:0] swal_eff(input logic [SWAL_W-1:0] a,
                                                 input logic [PROG_W-1:0] p_e);
    logic [PROG_W-1:0] a_wide;
    a_wide = {{(PROG_W-SWAL_W){1'b0}}, a};
    return (a_wide > p_e) ? p_e[SWAL_W-1:0] : a;
  endfunction

endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div
  import pll_synth_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             xtal_stb,
  input  logic [SEL_W-1:0] sel,
  output logic             ref_tick
);
  logic [REF_W-1:0] cnt_q;
  logic [REF_W-1:0] last_val;
  logic             at_last;

  assign last_val = ref_divisor(sel) - REF_W'(1);
  assign at_last  = (cnt_q >= last_val);
  assign ref_tick = xtal_stb && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (stop)      cnt_q <= '0;
    else if (xtal_stb)  cnt_q <= at_last ? '0 : cnt_q + REF_W'(1);
  end
endmodule

// File: rtl/pll_prog_div.sv
module pll_prog_div
  import pll_synth_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  input  logic              band_fm,
  input  logic [PROG_W-1:0] p_in,
  input  logic [SWAL_W-1:0] a_in,
  input  logic              lo_stb,
  output logic              div_tick
);
  logic [PRE_W-1:0]  pre_q;
  logic [PROG_W-1:0] prog_q;
  logic [SWAL_W-1:0] swal_q;
  logic [PROG_W-1:0] p_e, cur_prog;
  logic [SWAL_W-1:0] a_e, cur_swal;
  logic [PRE_W-1:0]  pre_last;
  logic              reload, pre_wrap, stage_tick;
  band_e             band;

  assign band     = band_e'(band_fm);
  assign p_e      = prog_eff(p_in);
  assign a_e      = swal_eff(a_in, p_e);
  // prog_q == 0 marks the start of a new divide cycle: load from the inputs.
  assign reload   = (prog_q == '0);
  assign cur_prog = reload ? p_e : prog_q;
  assign cur_swal = reload ? a_e : swal_q;
  // Divide by 17 while swallow count remains, by 16 afterwards.
  assign pre_last = (cur_swal != '0) ? PRE_W'(16) : PRE_W'(15);
  assign pre_wrap = (band == BAND_HIGH) ? (pre_q == pre_last) : 1'b1;
  assign stage_tick = lo_stb && pre_wrap;
  assign div_tick   = stage_tick && (cur_prog == PROG_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      prog_q <= '0;
      swal_q <= '0;
    end else if (stop) begin
      pre_q  <= '0;
      prog_q <= '0;
      swal_q <= '0;
    end else if (lo_stb) begin
      if (band == BAND_HIGH)
        pre_q <= pre_wrap ? '0 : pre_q + PRE_W'(1);
      else
        pre_q <= '0;
      if (stage_tick) begin
        if (cur_prog == PROG_W'(1)) begin
          prog_q <= '0;
          swal_q <= '0;
        end else begin
          prog_q <= cur_prog - PROG_W'(1);
          swal_q <= (cur_swal != '0) ? cur_swal - SWAL_W'(1) : '0;
        end
      end
    end
  end
endmodule

// File: rtl/pll_phase_det.sv
module pll_phase_det (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic ref_tick,
  input  logic div_tick,
  output logic up_q,
  output logic dn_q
);
  logic up_n, dn_n;

  assign up_n = up_q | div_tick;
  assign dn_n = dn_q | ref_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (stop || (up_n && dn_n)) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_n;
      dn_q <= dn_n;
    end
  end
endmodule

// File: rtl/pll_lock_mon.sv
module pll_lock_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic ref_tick,
  input  logic div_tick,
  input  logic ack,
  output logic flag_q
);
  localparam int CNT_W = 2;
  logic             armed_q;
  logic [CNT_W-1:0] seen_q;
  logic [CNT_W:0]   seen_incl;
  logic             miss_set;

  assign seen_incl = {1'b0, seen_q} + {{CNT_W{1'b0}}, div_tick};
  assign miss_set  = !stop && armed_q && ref_tick && (seen_incl != (CNT_W+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      seen_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      flag_q <= miss_set | (flag_q & ~ack);
      if (stop) begin
        armed_q <= 1'b0;
        seen_q  <= '0;
      end else if (ref_tick) begin
        armed_q <= 1'b1;
        seen_q  <= '0;
      end else if (div_tick && (seen_q != CNT_W'(2))) begin
        seen_q  <= seen_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
  import pll_synth_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_stb,
  input  logic              lo_stb,
  input  logic              band_fm,
  input  logic [SEL_W-1:0]  ref_sel,
  input  logic [PROG_W-1:0] prog_cnt,
  input  logic [SWAL_W-1:0] swal_cnt,
  input  logic              loop_stop,
  input  logic              unlock_ack,
  output logic              err_drive,
  output logic              err_level,
  output logic              unlock
);
  logic ref_tick, div_tick, up_q, dn_q;

  pll_ref_div u_ref (
    .clk(clk), .rst_n(rst_n), .stop(loop_stop),
    .xtal_stb(xtal_stb), .sel(ref_sel), .ref_tick(ref_tick)
  );

  pll_prog_div u_prog (
    .clk(clk), .rst_n(rst_n), .stop(loop_stop), .band_fm(band_fm),
    .p_in(prog_cnt), .a_in(swal_cnt), .lo_stb(lo_stb), .div_tick(div_tick)
  );

  pll_phase_det u_pd (
    .clk(clk), .rst_n(rst_n), .stop(loop_stop),
    .ref_tick(ref_tick), .div_tick(div_tick), .up_q(up_q), .dn_q(dn_q)
  );

  pll_lock_mon u_lock (
    .clk(clk), .rst_n(rst_n), .stop(loop_stop),
    .ref_tick(ref_tick), .div_tick(div_tick), .ack(unlock_ack), .flag_q(unlock)
  );

  assign err_drive = up_q | dn_q;
  assign err_level = up_q;
endmodule

// File: rtl/pll_synth_checker.sv
module pll_synth_checker (
  input logic clk,
  input logic rst_n,
  input logic loop_stop,
  input logic unlock_ack,
  input logic ref_tick,
  input logic div_tick,
  input logic err_drive,
  input logic err_level,
  input logic unlock
);
  // R8: stop floats the output on the next cycle
  p_stop_floats_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_stop |=> !err_drive);

  // R5: lone divided edge from float gives pump up
  p_div_first_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && !ref_tick && !loop_stop && !err_drive) |=> (err_drive && err_level));

  // R6: lone reference edge from float gives pump down
  p_ref_first_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !div_tick && !loop_stop && !err_drive) |=> (err_drive && !err_level));

  // R7: coincident edges leave the output floating
  p_coincide_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && div_tick && !err_drive) |=> !err_drive);

  // R7: the opposite edge ends a pending pulse
  p_pulse_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_drive && ((err_level && ref_tick) || (!err_level && div_tick))) |=> !err_drive);

  // R5, R6: no edge, no change
  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick && !div_tick && !loop_stop) |=> ($stable(err_drive) && $stable(err_level)));

  // R9: the flag only rises at a reference edge
  p_set_at_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlock && !(ref_tick && !loop_stop)) |=> !unlock);

  // R10: the flag only falls on a read
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && !unlock_ack) |=> unlock);
endmodule

bind pll_synth_core pll_synth_checker u_chk (
  .clk(clk), .rst_n(rst_n), .loop_stop(loop_stop), .unlock_ack(unlock_ack),
  .ref_tick(ref_tick), .div_tick(div_tick),
  .err_drive(err_drive), .err_level(err_level), .unlock(unlock)
);

// File: tb/tb_pll_synth_core.sv
module tb_pll_synth_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal_stb = 1'b0, lo_stb = 1'b0, band_fm = 1'b0;
  logic [2:0]  ref_sel = '0;
  logic [11:0] prog_cnt = 12'd1;
  logic [3:0]  swal_cnt = '0;
  logic        loop_stop = 1'b0, unlock_ack = 1'b0;
  logic        err_drive, err_level, unlock;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  int m_xc, m_lc, m_up, m_dn, m_armed, m_seen, m_flag;

  always #2.5 clk = ~clk;

  pll_synth_core dut (
    .clk(clk), .rst_n(rst_n), .xtal_stb(xtal_stb), .lo_stb(lo_stb),
    .band_fm(band_fm), .ref_sel(ref_sel), .prog_cnt(prog_cnt),
    .swal_cnt(swal_cnt), .loop_stop(loop_stop), .unlock_ack(unlock_ack),
    .err_drive(err_drive), .err_level(err_level), .unlock(unlock)
  );

  // R2: crystal strobes per reference edge
  function automatic int tb_ref_div(input int sel);
    int tbl[7] = '{75, 25, 24, 15, 12, 6, 3};
    return (sel < 7) ? tbl[sel] : 75;
  endfunction

  // R3, R4: oscillator strobes per divided edge
  function automatic int tb_ratio(input bit fm, input int p, input int a);
    int pe, ae;
    pe = (p == 0) ? 1 : p;
    ae = (a > pe) ? pe : a;
    return fm ? (16 * pe + ae) : pe;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      if (n_fail < 30) $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_xc = 0; m_lc = 0; m_up = 0; m_dn = 0; m_armed = 0; m_seen = 0;
  endtask

  task automatic model_step();
    int d, n, rt, dt, incl, nu, nd;
    if (loop_stop) begin
      model_clear();
      m_flag = m_flag && !unlock_ack;
      return;
    end
    d = tb_ref_div(ref_sel);
    n = tb_ratio(band_fm, prog_cnt, swal_cnt);
    rt = xtal_stb && (m_xc + 1 >= d);
    if (xtal_stb) m_xc = rt ? 0 : m_xc + 1;
    dt = lo_stb && (m_lc + 1 == n);
    if (lo_stb) m_lc = dt ? 0 : m_lc + 1;
    incl = m_seen + dt;
    m_flag = (m_armed && rt && incl != 1) || (m_flag && !unlock_ack);
    if (rt) begin m_armed = 1; m_seen = 0; end
    else if (dt && m_seen < 2) m_seen++;
    nu = m_up || dt;
    nd = m_dn || rt;
    if (nu && nd) begin m_up = 0; m_dn = 0; end
    else begin m_up = nu; m_dn = nd; end
  endtask

  // one cycle: inputs already driven after negedge; compare after the edge
  task automatic cycle(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(err_drive == (m_up || m_dn), {tag, " R5 R6 R7 drive"}, err_drive, m_up || m_dn);
    check(err_level == m_up, {tag, " R5 R6 level"}, err_level, m_up);
    check(unlock == m_flag, {tag, " R9 R10 unlock"}, unlock, m_flag);
  endtask

  task automatic do_stop(input bit fm, input int sel, input int p, input int a);
    xtal_stb = 0; lo_stb = 0; unlock_ack = 0; loop_stop = 1;
    band_fm = fm; ref_sel = 3'(sel); prog_cnt = 12'(p); swal_cnt = 4'(a);
    cycle("R8 stop");
    check(err_drive == 1'b0, "R8 float", err_drive, 0);
    cycle("R8 stop");
    loop_stop = 0;
  endtask

  initial begin : wdog
    int cnt;
    cnt = 0;
    while (!done && cnt < 190000) begin @(posedge clk); cnt++; end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cnt, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int seed, pa, pl;
    string tag;
    seed = $urandom(32'd4242);
    m_flag = 0;
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(err_drive == 1'b0, "R1 drive", err_drive, 0);
    check(unlock == 1'b0, "R1 unlock", unlock, 0);
    rst_n = 1;
    @(negedge clk);

    // R7 directed: both strobes every cycle, D=3 and low-band P=3 coincide
    do_stop(1'b0, 6, 3, 9);
    for (int i = 0; i < 60; i++) begin
      xtal_stb = 1; lo_stb = 1;
      cycle("R7 R4 coincide");
      check(err_drive == 1'b0, "R7 stays float", err_drive, 0);
    end
    check(unlock == 1'b0, "R9 locked case", unlock, 0);

    // R3 directed: A above P clamps (P=2, A=15 -> 34), R5 fast oscillator
    do_stop(1'b1, 6, 2, 15);
    for (int i = 0; i < 400; i++) begin
      xtal_stb = ($urandom % 8) == 0; lo_stb = 1;
      cycle("R3 clamp");
    end

    // R10 directed: read clears the flag
    unlock_ack = 0; xtal_stb = 0; lo_stb = 0;
    if (unlock) begin
      unlock_ack = 1;
      cycle("R10 ack");
      unlock_ack = 0;
      check(unlock == 1'b0, "R10 cleared", unlock, 0);
    end

    // random scenarios: R2, R3, R4 ratios under varied strobe densities
    for (int s = 0; s < 30; s++) begin
      bit fm;
      int sel, p, a;
      fm  = $urandom % 2;
      sel = $urandom % 8;
      p   = $urandom % 7;
      a   = $urandom % 16;
      do_stop(fm, sel, p, a);
      pa = 1 + $urandom % 4;
      pl = 1 + $urandom % 8;
      tag = fm ? "R2 R3 rand" : "R2 R4 rand";
      for (int i = 0; i < 1500; i++) begin
        xtal_stb = ($urandom % pa) == 0;
        lo_stb = ($urandom % pl) == 0;
        unlock_ack = ($urandom % 97) == 0;
        cycle(tag);
      end
      unlock_ack = 0;
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule